// File: doc/BRIEF.md
# Internal data memory mapper

This block resolves every access a small 8-bit microcontroller core makes to its 256-byte internal data space. Each request carries an access kind (direct, indirect, working register, single bit, push or pop), an 8-bit address and, for writes, a byte or a bit value. The block decides whether the request lands in general RAM, in the bit-addressable RAM window, or in a special function register, and performs the read or write there.

The upper half of the address space is shared by two stores. Direct accesses there reach the special function registers, while indirect and stack accesses reach the upper 128 bytes of RAM. A separate 256-entry bit address space is folded onto sixteen RAM bytes and onto the special function registers whose address is a multiple of eight. The block also owns the stack pointer, the status word that selects the working register bank, the accumulator, the B register and the two data pointer bytes.

Reads return one clock after the request on `rd_data` and `rd_bit`, qualified by `rd_valid`. Writes, including single-bit read-modify-writes and push sequencing, complete in the clock that accepts the request.

Top module: `idata_mapper`

## Requirements
- R1: After synchronous reset the stack pointer reads 0x07, the bank select (`bank_out`) is 0, and direct reads of 0xE0, 0xF0, 0xD0, 0x82 and 0x83 return 0x00.
- R2: With kind 0 (direct) and address 0x00–0x7F, a write stores the byte in RAM and a read returns it; read data appears with `rd_valid` high in the cycle after the request.
- R3: With kind 0 and address 0x80–0xFF, the access reaches the special function registers: accumulator 0xE0, B 0xF0, status word 0xD0, stack pointer 0x81, data pointer low 0x82, high 0x83.
- R4: With kind 1 (indirect) any address, including 0x80–0xFF, reaches RAM and never a special function register.
- R5: With kind 2 (register) the register number is `req_addr[2:0]` and the RAM byte used is bank*8 + n, where bank is status bits 4:3 and is shown on `bank_out`.
- R6: With kind 3 (bit) and bit address 0x00–0x7F, the bit is bit `a[2:0]` of RAM byte 0x20 + `a[6:3]`; a bit write changes only that bit.
- R7: With kind 3 and bit address 0x80–0xFF, the bit lies in the register at `a & 0xF8`; 0xD7 is the status carry and 0xD3/0xD4 are the bank select bits.
- R8: Kind 4 (push) increments the stack pointer and writes `req_wdata` to RAM at the new value in the same clock; 0xFF wraps to 0x00.
- R9: Kind 5 (pop) returns RAM at the stack pointer and then decrements it; 0x00 wraps to 0xFF.
- R10: Writes to unimplemented special function register addresses, byte or bit, change nothing, and reads of them return 0x00.
- R11: Kinds 6 and 7, and cycles with `req_valid` low, change no state and give no read response.
- R12: `rd_valid` rises only for reads and pops; when it is low `rd_data` and `rd_bit` are 0; for a bit read `rd_data` holds the containing byte and `rd_bit` the selected bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind: 0 direct, 1 indirect, 2 register, 3 bit, 4 push, 5 pop |
| req_we | input | 1 | Write when high, read when low (ignored for push and pop) |
| req_addr | input | 8 | Byte address, register number or bit address |
| req_wdata | input | 8 | Byte write data and push data |
| req_wbit | input | 1 | Bit write value |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 8 | Read byte |
| rd_bit | output | 1 | Selected bit of a bit read |
| sp_out | output | 8 | Current stack pointer |
| bank_out | output | 2 | Current working register bank |

## Verification
A push moves the stack pointer and writes RAM at the moved value in one clock, and a pop reads at the old value while decrementing; both meet in one cycle with any change to the pointer, and a push landing in 0x20–0x2F also meets the bit window. The bench provokes this with back-to-back push and pop runs from a stack pointer just written directly (0xFF, 0x1F), and by bit writes to the bank bits followed at once by register accesses. Each response is judged against a bench model of RAM and registers updated in request order, comparing read data, the stack pointer and the bank every cycle.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int BIT_IDX_W  = $clog2(DATA_W);
  localparam int BITF_BYTES = 16;
  localparam logic [ADDR_W-1:0] BITF_BASE = 8'h20;

  localparam logic [ADDR_W-1:0] A_ACC = 8'hE0;
  localparam logic [ADDR_W-1:0] A_B   = 8'hF0;
  localparam logic [ADDR_W-1:0] A_PSW = 8'hD0;
  localparam logic [ADDR_W-1:0] A_SP  = 8'h81;
  localparam logic [ADDR_W-1:0] A_DPL = 8'h82;
  localparam logic [ADDR_W-1:0] A_DPH = 8'h83;
  localparam logic [DATA_W-1:0] SP_RESET = 8'h07;

  typedef enum logic [2:0] {
    K_DIR  = 3'd0,
    K_IND  = 3'd1,
    K_REG  = 3'd2,
    K_BIT  = 3'd3,
    K_PUSH = 3'd4,
    K_POP  = 3'd5
  } req_kind_e;

  typedef enum logic [1:0] {
    TG_NONE = 2'd0,
    TG_RAM  = 2'd1,
    TG_BITF = 2'd2,
    TG_SFR  = 2'd3
  } tgt_e;
endpackage

// File: rtl/idm_decode.sv
module idm_decode
  import idm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = BIT_IDX_W
) (
  input  logic [2:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    bank,
  input  logic [AW-1:0] sp,
  output tgt_e          tgt,
  output logic [AW-1:0] byte_addr,
  output logic [IW-1:0] bit_idx,
  output logic          is_bit
);
  localparam int BANK_SH = 3;

  logic          ram_sel;
  logic [AW-1:0] ram_a;
  logic [AW-1:0] sfr_a;
  logic          sfr_sel;

  always_comb begin
    ram_sel = 1'b0;
    sfr_sel = 1'b0;
    ram_a   = '0;
    sfr_a   = '0;
    is_bit  = 1'b0;
    bit_idx = addr[IW-1:0];
    case (kind)
      K_DIR: begin
        if (addr[AW-1]) begin
          sfr_sel = 1'b1;
          sfr_a   = addr;
        end else begin
          ram_sel = 1'b1;
          ram_a   = addr;
        end
      end
      K_IND: begin
        ram_sel = 1'b1;
        ram_a   = addr;
      end
      K_REG: begin
        ram_sel = 1'b1;
        ram_a   = AW'({bank, addr[BANK_SH-1:0]});
      end
      K_BIT: begin
        is_bit = 1'b1;
        if (addr[AW-1]) begin
          sfr_sel = 1'b1;
          sfr_a   = {addr[AW-1:IW], {IW{1'b0}}};
        end else begin
          ram_sel = 1'b1;
          ram_a   = BITF_BASE + AW'(addr[AW-2:IW]);
        end
      end
      K_PUSH: begin
        ram_sel = 1'b1;
        ram_a   = sp + AW'(1);
      end
      K_POP: begin
        ram_sel = 1'b1;
        ram_a   = sp;
      end
      default: ;
    endcase

    tgt       = TG_NONE;
    byte_addr = '0;
    if (sfr_sel) begin
      tgt       = TG_SFR;
      byte_addr = sfr_a;
    end else if (ram_sel) begin
      byte_addr = ram_a;
      if (ram_a >= BITF_BASE && ram_a < BITF_BASE + AW'(BITF_BYTES))
        tgt = TG_BITF;
      else
        tgt = TG_RAM;
    end
  end
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/idm_bitfile.sv
module idm_bitfile #(
  parameter int NBYTES = 16,
  parameter int DW     = 8,
  parameter int XW     = $clog2(NBYTES),
  parameter int IW     = $clog2(DW)
) (
  input  logic          clk,
  input  logic          we_byte,
  input  logic          we_bit,
  input  logic [XW-1:0] idx,
  input  logic [IW-1:0] bit_sel,
  input  logic [DW-1:0] wdata,
  input  logic          wbit,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [NBYTES];

  assign rdata = cells[idx];

  for (genvar g = 0; g < NBYTES; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (idx == XW'(g)) begin
        if (we_byte)
          cells[g] <= wdata;
        else if (we_bit)
          cells[g][bit_sel] <= wbit;
      end
    end
  end
endmodule

// File: rtl/idm_sfr.sv
module idm_sfr
  import idm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int IW = BIT_IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          we_byte,
  input  logic          we_bit,
  input  logic [IW-1:0] bit_sel,
  input  logic [DW-1:0] wdata,
  input  logic          wbit,
  input  logic          sp_inc,
  input  logic          sp_dec,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] sp,
  output logic [1:0]    bank
);
  localparam int BANK_LO = 3;

  logic [DW-1:0] acc_q, b_q, psw_q, dpl_q, dph_q;
  logic [DW-1:0] merged;
  logic [DW-1:0] wr_val;
  logic          wr;

  always_comb begin
    case (addr)
      A_ACC:   rdata = acc_q;
      A_B:     rdata = b_q;
      A_PSW:   rdata = psw_q;
      A_SP:    rdata = sp;
      A_DPL:   rdata = dpl_q;
      A_DPH:   rdata = dph_q;
      default: rdata = '0;
    endcase
  end

  always_comb begin
    merged          = rdata;
    merged[bit_sel] = wbit;
  end

  assign wr     = we_byte | we_bit;
  assign wr_val = we_bit ? merged : wdata;
  assign bank   = psw_q[BANK_LO+1:BANK_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      b_q   <= '0;
      psw_q <= '0;
      dpl_q <= '0;
      dph_q <= '0;
      sp    <= SP_RESET;
    end else begin
      if (sp_inc)      sp <= sp + DW'(1);
      else if (sp_dec) sp <= sp - DW'(1);
      if (wr) begin
        case (addr)
          A_ACC:   acc_q <= wr_val;
          A_B:     b_q   <= wr_val;
          A_PSW:   psw_q <= wr_val;
          A_SP:    sp    <= wr_val;
          A_DPL:   dpl_q <= wr_val;
          A_DPH:   dph_q <= wr_val;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/idata_mapper.sv
module idata_mapper
  import idm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NBITF = BITF_BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_wbit,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_bit,
  output logic [DW-1:0] sp_out,
  output logic [1:0]    bank_out
);
  localparam int IW = $clog2(DW);
  localparam int XW = $clog2(NBITF);

  tgt_e          tgt;
  logic [AW-1:0] byte_addr;
  logic [IW-1:0] bit_idx;
  logic          is_bit;
  logic          known, is_push, is_pop, do_write, do_read;
  logic [DW-1:0] ram_q, bitf_rd, sfr_rd;

  tgt_e          src_q;
  logic [DW-1:0] bitf_q, sfr_q;
  logic [IW-1:0] idx_q;
  logic          isbit_q;

  assign known    = req_kind <= K_POP;
  assign is_push  = req_valid && req_kind == K_PUSH;
  assign is_pop   = req_valid && req_kind == K_POP;
  assign do_write = req_valid && known && (is_push || (req_we && !is_pop));
  assign do_read  = req_valid && known && (is_pop || (!is_push && !req_we));

  idm_decode #(.AW(AW), .IW(IW)) u_dec (
    .kind      (req_kind),
    .addr      (req_addr),
    .bank      (bank_out),
    .sp        (sp_out),
    .tgt       (tgt),
    .byte_addr (byte_addr),
    .bit_idx   (bit_idx),
    .is_bit    (is_bit)
  );

  idm_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (do_write && tgt == TG_RAM),
    .addr  (byte_addr),
    .wdata (req_wdata),
    .q     (ram_q)
  );

  idm_bitfile #(.NBYTES(NBITF), .DW(DW)) u_bitf (
    .clk     (clk),
    .we_byte (do_write && tgt == TG_BITF && !is_bit),
    .we_bit  (do_write && tgt == TG_BITF && is_bit),
    .idx     (byte_addr[XW-1:0]),
    .bit_sel (bit_idx),
    .wdata   (req_wdata),
    .wbit    (req_wbit),
    .rdata   (bitf_rd)
  );

  idm_sfr #(.AW(AW), .DW(DW), .IW(IW)) u_sfr (
    .clk     (clk),
    .rst     (rst),
    .addr    (byte_addr),
    .we_byte (do_write && tgt == TG_SFR && !is_bit),
    .we_bit  (do_write && tgt == TG_SFR && is_bit),
    .bit_sel (bit_idx),
    .wdata   (req_wdata),
    .wbit    (req_wbit),
    .sp_inc  (is_push),
    .sp_dec  (is_pop),
    .rdata   (sfr_rd),
    .sp      (sp_out),
    .bank    (bank_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      src_q    <= TG_NONE;
      bitf_q   <= '0;
      sfr_q    <= '0;
      idx_q    <= '0;
      isbit_q  <= 1'b0;
    end else begin
      rd_valid <= do_read;
      src_q    <= do_read ? tgt : TG_NONE;
      bitf_q   <= bitf_rd;
      sfr_q    <= sfr_rd;
      idx_q    <= bit_idx;
      isbit_q  <= do_read && is_bit;
    end
  end

  always_comb begin
    case (src_q)
      TG_RAM:  rd_data = ram_q;
      TG_BITF: rd_data = bitf_q;
      TG_SFR:  rd_data = sfr_q;
      default: rd_data = '0;
    endcase
  end

  assign rd_bit = isbit_q && rd_data[idx_q];
endmodule

// File: rtl/idm_chk.sv
module idm_chk
  import idm_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic       req_we,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       rd_bit,
  input logic [7:0] sp_out,
  input logic [1:0] bank_out
);
  // R1
  sp_reset_chk: assert property (@(posedge clk)
    rst |=> (sp_out == 8'h07 && bank_out == 2'b00));

  // R8
  push_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == K_PUSH) |=> sp_out == $past(sp_out) + 8'd1);

  // R9
  pop_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == K_POP) |=> (rd_valid && sp_out == $past(sp_out) - 8'd1));

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_kind > K_POP) |=> (!rd_valid && $stable(sp_out) && $stable(bank_out)));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_we && (req_kind == K_DIR || req_kind == K_BIT)) |=> $stable(bank_out));

  // R12
  no_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == 8'h00 && !rd_bit));

  // R12
  push_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == K_PUSH) |=> !rd_valid);
endmodule

bind idata_mapper idm_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_we    (req_we),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .rd_bit    (rd_bit),
  .sp_out    (sp_out),
  .bank_out  (bank_out)
);

// File: tb/idata_mapper_tb_top.sv
`timescale 1ns/1ps
module idata_mapper_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic       req_we = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_wbit = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_bit;
  logic [7:0] sp_out;
  logic [1:0] bank_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  idata_mapper dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wbit(req_wbit), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_bit(rd_bit), .sp_out(sp_out), .bank_out(bank_out)
  );

  // bench model
  logic [7:0] m_ram [256];
  logic [7:0] m_acc, m_b, m_psw, m_sp, m_dpl, m_dph;

  function automatic logic [7:0] m_sfr_rd(input logic [7:0] a);
    case (a)
      8'hE0: return m_acc;
      8'hF0: return m_b;
      8'hD0: return m_psw;
      8'h81: return m_sp;
      8'h82: return m_dpl;
      8'h83: return m_dph;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_sfr_wr(input logic [7:0] a, input logic [7:0] v);
    case (a)
      8'hE0: m_acc = v;
      8'hF0: m_b   = v;
      8'hD0: m_psw = v;
      8'h81: m_sp  = v;
      8'h82: m_dpl = v;
      8'h83: m_dph = v;
      default: ;
    endcase
  endtask

  // one request, called at a falling edge; checks response one clock later
  task automatic xfer(input logic [2:0] k, input logic we, input logic [7:0] a,
                      input logic [7:0] wd, input logic wb, input string tag);
    logic       e_valid, e_bit;
    logic [7:0] cur, nb, ba, e_data;
    cur = 8'h00;
    e_valid = (k <= 3'd5) && (k == 3'd5 || (k != 3'd4 && !we));
    case (k)
      3'd0: begin
        if (a[7]) begin cur = m_sfr_rd(a); if (we) m_sfr_wr(a, wd); end
        else begin cur = m_ram[a]; if (we) m_ram[a] = wd; end
      end
      3'd1: begin cur = m_ram[a]; if (we) m_ram[a] = wd; end
      3'd2: begin
        ba = {3'b000, m_psw[4:3], a[2:0]};
        cur = m_ram[ba]; if (we) m_ram[ba] = wd;
      end
      3'd3: begin
        if (!a[7]) begin
          ba = 8'h20 + {4'h0, a[6:3]};
          cur = m_ram[ba]; nb = cur; nb[a[2:0]] = wb;
          if (we) m_ram[ba] = nb;
        end else begin
          ba = {a[7:3], 3'b000};
          cur = m_sfr_rd(ba); nb = cur; nb[a[2:0]] = wb;
          if (we) m_sfr_wr(ba, nb);
        end
      end
      3'd4: begin m_sp = m_sp + 8'd1; m_ram[m_sp] = wd; end
      3'd5: begin cur = m_ram[m_sp]; m_sp = m_sp - 8'd1; end
      default: ;
    endcase
    e_data = e_valid ? cur : 8'h00;
    e_bit  = (e_valid && k == 3'd3) ? cur[a[2:0]] : 1'b0;

    req_valid = 1'b1; req_kind = k; req_we = we;
    req_addr = a; req_wdata = wd; req_wbit = wb;
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (rd_valid !== e_valid || rd_data !== e_data || rd_bit !== e_bit ||
        sp_out !== m_sp || bank_out !== m_psw[4:3]) begin
      errors++;
      $display("FAIL %s kind=%0d we=%0d addr=%02h: valid=%0d data=%02h bit=%0d sp=%02h bank=%0d expected valid=%0d data=%02h bit=%0d sp=%02h bank=%0d",
               tag, k, we, a, rd_valid, rd_data, rd_bit, sp_out, bank_out,
               e_valid, e_data, e_bit, m_sp, m_psw[4:3]);
    end
  endtask

  function automatic string kind_tag(input logic [2:0] k, input logic [7:0] a);
    case (k)
      3'd0: return a[7] ? "R3" : "R2";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return a[7] ? "R7" : "R6";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R11";
    endcase
  endfunction

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h51A7);
    m_acc = 0; m_b = 0; m_psw = 0; m_sp = 8'h07; m_dpl = 0; m_dph = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    checks++;
    if (sp_out !== 8'h07 || bank_out !== 2'b00 || rd_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: sp=%02h bank=%0d valid=%0d expected sp=07 bank=0 valid=0",
               sp_out, bank_out, rd_valid);
    end
    xfer(3'd0, 1'b0, 8'hE0, 8'h00, 1'b0, "R1");
    xfer(3'd0, 1'b0, 8'hF0, 8'h00, 1'b0, "R1");
    xfer(3'd0, 1'b0, 8'hD0, 8'h00, 1'b0, "R1");
    xfer(3'd0, 1'b0, 8'h82, 8'h00, 1'b0, "R1");
    xfer(3'd0, 1'b0, 8'h83, 8'h00, 1'b0, "R1");

    // R4: fill all RAM indirectly
    for (int i = 0; i < 256; i++)
      xfer(3'd1, 1'b1, 8'(i), 8'(i * 37) ^ 8'h5A, 1'b0, "R4");

    // R2 / R3 / R4: same upper address, two stores
    xfer(3'd0, 1'b1, 8'h30, 8'hC3, 1'b0, "R2");
    xfer(3'd0, 1'b0, 8'h30, 8'h00, 1'b0, "R2");
    xfer(3'd0, 1'b1, 8'hE0, 8'h3C, 1'b0, "R3");
    xfer(3'd1, 1'b0, 8'hE0, 8'h00, 1'b0, "R4");
    xfer(3'd0, 1'b0, 8'hE0, 8'h00, 1'b0, "R3");
    xfer(3'd1, 1'b1, 8'hF0, 8'h99, 1'b0, "R4");
    xfer(3'd0, 1'b0, 8'hF0, 8'h00, 1'b0, "R3");

    // R7 / R5: bank bits then register access straight after
    xfer(3'd3, 1'b1, 8'hD3, 8'h00, 1'b1, "R7");
    xfer(3'd2, 1'b1, 8'h02, 8'hA7, 1'b0, "R5");
    xfer(3'd0, 1'b0, 8'h0A, 8'h00, 1'b0, "R5");
    xfer(3'd3, 1'b1, 8'hD4, 8'h00, 1'b1, "R7");
    xfer(3'd2, 1'b0, 8'h07, 8'h00, 1'b0, "R5");
    xfer(3'd3, 1'b1, 8'hD7, 8'h00, 1'b1, "R7");
    xfer(3'd0, 1'b0, 8'hD0, 8'h00, 1'b0, "R7");
    xfer(3'd3, 1'b0, 8'hD7, 8'h00, 1'b0, "R12");

    // R6: bit window in RAM
    xfer(3'd1, 1'b1, 8'h21, 8'h00, 1'b0, "R6");
    xfer(3'd3, 1'b1, 8'h0F, 8'h00, 1'b1, "R6");
    xfer(3'd1, 1'b0, 8'h21, 8'h00, 1'b0, "R6");
    xfer(3'd3, 1'b0, 8'h0F, 8'h00, 1'b0, "R12");
    xfer(3'd3, 1'b1, 8'h7A, 8'h00, 1'b0, "R6");
    xfer(3'd1, 1'b0, 8'h2F, 8'h00, 1'b0, "R6");

    // R8 / R9: wrap
    xfer(3'd0, 1'b1, 8'h81, 8'hFF, 1'b0, "R3");
    xfer(3'd4, 1'b0, 8'h00, 8'hE1, 1'b0, "R8");
    xfer(3'd1, 1'b0, 8'h00, 8'h00, 1'b0, "R8");
    xfer(3'd5, 1'b0, 8'h00, 8'h00, 1'b0, "R9");
    xfer(3'd5, 1'b0, 8'h00, 8'h00, 1'b0, "R9");
    xfer(3'd0, 1'b1, 8'h81, 8'h1F, 1'b0, "R8");
    xfer(3'd4, 1'b0, 8'h00, 8'hA5, 1'b0, "R8");
    xfer(3'd3, 1'b0, 8'h05, 8'h00, 1'b0, "R8");
    xfer(3'd4, 1'b0, 8'h00, 8'h5A, 1'b0, "R8");
    xfer(3'd5, 1'b0, 8'h00, 8'h00, 1'b0, "R9");
    xfer(3'd5, 1'b0, 8'h00, 8'h00, 1'b0, "R9");

    // R10: unimplemented registers
    xfer(3'd0, 1'b1, 8'h90, 8'h77, 1'b0, "R10");
    xfer(3'd0, 1'b0, 8'h90, 8'h00, 1'b0, "R10");
    xfer(3'd3, 1'b1, 8'h85, 8'h00, 1'b1, "R10");
    xfer(3'd3, 1'b0, 8'h85, 8'h00, 1'b0, "R10");
    xfer(3'd1, 1'b0, 8'h90, 8'h00, 1'b0, "R10");

    // R11: undefined kinds and idle cycles
    xfer(3'd6, 1'b1, 8'h30, 8'hFF, 1'b1, "R11");
    xfer(3'd7, 1'b0, 8'h30, 8'h00, 1'b0, "R11");
    xfer(3'd0, 1'b0, 8'h30, 8'h00, 1'b0, "R11");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] k;
      logic [7:0] a;
      logic we;
      k  = 3'($urandom % 7);
      we = 1'($urandom % 2);
      a  = 8'($urandom);
      if (k == 3'd0 && ($urandom % 3) == 0) begin
        case ($urandom % 6)
          0: a = 8'hE0; 1: a = 8'hF0; 2: a = 8'hD0;
          3: a = 8'h81; 4: a = 8'h82; default: a = 8'h83;
        endcase
      end
      if (k == 3'd3 && ($urandom % 3) == 0) a = {5'b11010, a[2:0]};
      xfer(k, we, a, 8'($urandom), 1'($urandom % 2), kind_tag(k, a));
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule